// File: doc/BRIEF.md
# Branch Resolution Unit

This unit settles the outcome of a branch in a core that mixes 16-bit and 32-bit instruction encodings. The decode stage supplies a branch kind, a raw offset field, a condition code, the four arithmetic flags, the address of the branch instruction, its encoding width, and the index and value of a register operand. One clock later the unit reports whether the branch is taken, where it goes, whether the return-address register must be written and with what value, and whether the branch must fault instead.

Four families are handled. The short unconditional jump, the conditional jump and the long jump-and-link all add a halfword-scaled displacement to the instruction address plus four. Each uses its own field width, so each has its own reach. The two register-indirect forms, with and without link, take their destination from the register operand. Bit 0 of that operand must be set, or the unit raises a fault request. Addressing the stack pointer or the program counter as that operand raises a separate misuse flag.

All results are registered. The unit keeps no state beyond that one output stage, so a new request may be presented every cycle.

Top module: `branch_resolve_unit`

## Requirements
- R1: All outputs come from registers and reflect the request presented at the previous rising edge. Reset clears every output. A cycle with `req_i` low, or with a kind code other than 1 to 5, leaves `valid_o`, `taken_o`, `lr_we_o`, `fault_o`, `unpred_o`, `target_o` and `lr_val_o` at 0 after the next edge.
- R2: Kind 1 (short unconditional jump) is always taken. Its target is `pc_i + 4 + 2*s`, where s is `off_i[10:0]` sign-extended. Offset bits above bit 10 have no effect, which gives a reach of -2048 to +2046 bytes around `pc_i + 4`.
- R3: Kind 2 (conditional jump) uses `off_i[7:0]` sign-extended with the same target formula. It is taken only when the condition holds. Flags are `flags_i = {N,Z,C,V}` (N at bit 3). The condition codes are: 0: Z; 1: !Z; 2: C; 3: !C; 4: N; 5: !N; 6: V; 7: !V; 8: C&!Z; 9: !C|Z; 10: N==V; 11: N!=V; 12: !Z&(N==V); 13: Z|(N!=V); 14: always; 15: never.
- R4: Kind 3 (long jump-and-link) uses `off_i[23:0]` sign-extended with the same target formula. It is always taken and always writes the link register.
- R5: Kind 4 (indirect jump) with `rm_val_i[0] = 1` is taken. Its target is `rm_val_i` with bit 0 cleared, and it does not write the link register.
- R6: Kinds 4 and 5 with `rm_val_i[0] = 0` raise `fault_o`, keep `taken_o` and `lr_we_o` low, and still report the cleared register value on `target_o`.
- R7: The link value is `pc_i + 4` when `wide_i` is 1 and `pc_i + 2` when it is 0, with bit 0 forced to 1. Kind 5 (indirect jump-and-link) with `rm_val_i[0] = 1` is taken and writes this value, targeting `rm_val_i` with bit 0 cleared.
- R8: `unpred_o` is set for kinds 4 and 5 when `rm_idx_i` is 13 or 15, and is never set for kinds 1 to 3. The branch otherwise resolves as usual.
- R9: Every reported target has bit 0 cleared, and every written link value has bit 0 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | A branch is presented this cycle |
| kind_i | input | 3 | Branch kind: 1 short, 2 conditional, 3 long link, 4 indirect, 5 indirect link |
| off_i | input | OFF_W (24) | Raw halfword offset field, LSB-aligned |
| cond_i | input | 4 | Condition code for kind 2 |
| flags_i | input | 4 | {N,Z,C,V} |
| pc_i | input | ADDR_W (32) | Address of the branch instruction |
| wide_i | input | 1 | 1 when the branch is a 32-bit encoding |
| rm_idx_i | input | 4 | Register operand index |
| rm_val_i | input | ADDR_W (32) | Register operand value |
| valid_o | output | 1 | A recognised branch was resolved |
| taken_o | output | 1 | Branch redirects fetch |
| target_o | output | ADDR_W (32) | Destination address |
| lr_we_o | output | 1 | Write the link register |
| lr_val_o | output | ADDR_W (32) | Value for the link register |
| fault_o | output | 1 | Indirect operand had bit 0 clear |
| unpred_o | output | 1 | Indirect operand was SP or PC |

## Verification
The output stage is the only state, so any wrong value there shows up at the ports on the cycle after the request and nowhere else. A corrupted field slice or sign extension appears as a wrong `target_o` at the extremes of each reach, which the table checks directly. A wrong condition entry appears as a wrong `taken_o` during the exhaustive sweep of all 16 codes against all 16 flag patterns. A fault that leaks into the link-write or taken paths, or an even link value, is caught in the same cycle by the bench and by the in-line properties.

// File: rtl/brres_pkg.sv
package brres_pkg;

    typedef enum logic [2:0] {
        BK_NONE     = 3'd0,
        BK_SHORT    = 3'd1,
        BK_COND     = 3'd2,
        BK_LONGLINK = 3'd3,
        BK_IND      = 3'd4,
        BK_INDLINK  = 3'd5
    } br_kind_e;

    localparam logic [3:0] IDX_SP = 4'd13;
    localparam logic [3:0] IDX_PC = 4'd15;

    localparam int N_REL = 3;

endpackage

// File: rtl/brres_cond.sv
module brres_cond (
    input  logic [3:0] code_i,
    input  logic [3:0] nzcv_i,
    output logic       pass_o
);
    logic n, z, c, v;

    always_comb begin
        n = nzcv_i[3];
        z = nzcv_i[2];
        c = nzcv_i[1];
        v = nzcv_i[0];
        case (code_i)
            4'd0:    pass_o = z;
            4'd1:    pass_o = !z;
            4'd2:    pass_o = c;
            4'd3:    pass_o = !c;
            4'd4:    pass_o = n;
            4'd5:    pass_o = !n;
            4'd6:    pass_o = v;
            4'd7:    pass_o = !v;
            4'd8:    pass_o = c && !z;
            4'd9:    pass_o = !c || z;
            4'd10:   pass_o = (n == v);
            4'd11:   pass_o = (n != v);
            4'd12:   pass_o = !z && (n == v);
            4'd13:   pass_o = z || (n != v);
            4'd14:   pass_o = 1'b1;
            default: pass_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/brres_reladdr.sv
module brres_reladdr #(
    parameter int ADDR_W  = 32,
    parameter int FIELD_W = 11
) (
    input  logic [ADDR_W-1:0]  pc_i,
    input  logic [FIELD_W-1:0] field_i,
    output logic [ADDR_W-1:0]  tgt_o
);
    localparam int EXT_W = ADDR_W - FIELD_W - 1;

    logic [ADDR_W-1:0] disp;
    logic [ADDR_W-1:0] sum;

    assign disp  = {{EXT_W{field_i[FIELD_W-1]}}, field_i, 1'b0};
    assign sum   = pc_i + ADDR_W'(4) + disp;
    assign tgt_o = sum & ~ADDR_W'(1);

endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
    import brres_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 24,
    parameter int SHORT_W = 11,
    parameter int COND_W  = 8,
    parameter int LONG_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [2:0]        kind_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [3:0]        cond_i,
    input  logic [3:0]        flags_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              wide_i,
    input  logic [3:0]        rm_idx_i,
    input  logic [ADDR_W-1:0] rm_val_i,
    output logic              valid_o,
    output logic              taken_o,
    output logic [ADDR_W-1:0] target_o,
    output logic              lr_we_o,
    output logic [ADDR_W-1:0] lr_val_o,
    output logic              fault_o,
    output logic              unpred_o
);

    typedef struct packed {
        logic              valid;
        logic              taken;
        logic [ADDR_W-1:0] target;
        logic              lr_we;
        logic [ADDR_W-1:0] lr_val;
        logic              fault;
        logic              unpred;
    } res_t;

    res_t res_d, res_q;

    logic [ADDR_W-1:0] rel_tgt [N_REL];
    logic              cond_pass;

    for (genvar g = 0; g < N_REL; g++) begin : g_rel
        localparam int FW = (g == 0) ? SHORT_W : ((g == 1) ? COND_W : LONG_W);
        brres_reladdr #(
            .ADDR_W  (ADDR_W),
            .FIELD_W (FW)
        ) i_rel (
            .pc_i    (pc_i),
            .field_i (off_i[FW-1:0]),
            .tgt_o   (rel_tgt[g])
        );
    end

    brres_cond i_cond (
        .code_i (cond_i),
        .nzcv_i (flags_i),
        .pass_o (cond_pass)
    );

    logic [ADDR_W-1:0] link_val;
    logic [ADDR_W-1:0] rm_tgt;
    logic              rm_bad;

    always_comb begin
        link_val = (pc_i + (wide_i ? ADDR_W'(4) : ADDR_W'(2))) | ADDR_W'(1);
        rm_tgt   = rm_val_i & ~ADDR_W'(1);
        rm_bad   = (rm_idx_i == IDX_SP) || (rm_idx_i == IDX_PC);

        res_d = '0;
        if (req_i) begin
            case (br_kind_e'(kind_i))
                BK_SHORT: begin
                    res_d.valid  = 1'b1;
                    res_d.taken  = 1'b1;
                    res_d.target = rel_tgt[0];
                end
                BK_COND: begin
                    res_d.valid  = 1'b1;
                    res_d.taken  = cond_pass;
                    res_d.target = rel_tgt[1];
                end
                BK_LONGLINK: begin
                    res_d.valid  = 1'b1;
                    res_d.taken  = 1'b1;
                    res_d.target = rel_tgt[2];
                    res_d.lr_we  = 1'b1;
                    res_d.lr_val = link_val;
                end
                BK_IND, BK_INDLINK: begin
                    res_d.valid  = 1'b1;
                    res_d.target = rm_tgt;
                    res_d.unpred = rm_bad;
                    res_d.fault  = !rm_val_i[0];
                    res_d.taken  = rm_val_i[0];
                    if (kind_i == BK_INDLINK && rm_val_i[0]) begin
                        res_d.lr_we  = 1'b1;
                        res_d.lr_val = link_val;
                    end
                end
                default: res_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign valid_o  = res_q.valid;
    assign taken_o  = res_q.taken;
    assign target_o = res_q.target;
    assign lr_we_o  = res_q.lr_we;
    assign lr_val_o = res_q.lr_val;
    assign fault_o  = res_q.fault;
    assign unpred_o = res_q.unpred;

    AST_NO_REQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !valid_o) else $error("AST_NO_REQ_QUIET"); // R1

    AST_IDLE_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> !(taken_o || lr_we_o || fault_o || unpred_o)) else $error("AST_IDLE_OUTPUTS"); // R1

    AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (!taken_o && !lr_we_o)) else $error("AST_FAULT_BLOCKS"); // R6

    AST_UNPRED_RESOLVES: assert property (@(posedge clk) disable iff (!rst_n)
        unpred_o |-> (taken_o ^ fault_o)) else $error("AST_UNPRED_RESOLVES"); // R8

    AST_LINK_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we_o |-> lr_val_o[0]) else $error("AST_LINK_ODD"); // R9

    AST_TARGET_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !target_o[0]) else $error("AST_TARGET_EVEN"); // R9

endmodule

// File: tb/test_branch_resolve_unit.sv
`timescale 1ns/1ps
module test_branch_resolve_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [2:0]  kind_i = '0;
    logic [23:0] off_i = '0;
    logic [3:0]  cond_i = '0;
    logic [3:0]  flags_i = '0;
    logic [31:0] pc_i = '0;
    logic        wide_i = 1'b0;
    logic [3:0]  rm_idx_i = '0;
    logic [31:0] rm_val_i = '0;
    logic        valid_o, taken_o, lr_we_o, fault_o, unpred_o;
    logic [31:0] target_o, lr_val_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    branch_resolve_unit i_branch_resolve_unit (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .kind_i(kind_i), .off_i(off_i),
        .cond_i(cond_i), .flags_i(flags_i), .pc_i(pc_i), .wide_i(wide_i),
        .rm_idx_i(rm_idx_i), .rm_val_i(rm_val_i), .valid_o(valid_o), .taken_o(taken_o),
        .target_o(target_o), .lr_we_o(lr_we_o), .lr_val_o(lr_val_o),
        .fault_o(fault_o), .unpred_o(unpred_o)
    );

    typedef struct packed {
        logic [2:0]  kind;
        logic [23:0] off;
        logic [3:0]  cond;
        logic [3:0]  flags;
        logic [31:0] pc;
        logic [31:0] rm;
        logic [3:0]  idx;
        logic        wide;
        logic        e_taken;
        logic [31:0] e_tgt;
        logic        e_lrwe;
        logic [31:0] e_lr;
        logic        e_fault;
        logic        e_unpred;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 24'hABC3FF, 4'd0, 4'h0, 32'h1000, 32'h0, 4'd0, 1'b0, 1'b1, 32'h1802, 1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd1, 24'h000400, 4'd0, 4'h0, 32'h1000, 32'h0, 4'd0, 1'b0, 1'b1, 32'h0804, 1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd2, 24'h000080, 4'd0, 4'h4, 32'h1000, 32'h0, 4'd0, 1'b0, 1'b1, 32'h0F04, 1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd2, 24'h00007F, 4'd0, 4'h0, 32'h1000, 32'h0, 4'd0, 1'b0, 1'b0, 32'h1102, 1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd2, 24'hFFFF01, 4'd12, 4'h9, 32'h1000, 32'h0, 4'd0, 1'b0, 1'b1, 32'h1006, 1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd2, 24'h000000, 4'd11, 4'h8, 32'h1000, 32'h0, 4'd0, 1'b0, 1'b1, 32'h1004, 1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd2, 24'h000000, 4'd15, 4'hF, 32'h1000, 32'h0, 4'd0, 1'b0, 1'b0, 32'h1004, 1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd2, 24'h000000, 4'd8, 4'h6, 32'h1000, 32'h0, 4'd0, 1'b0, 1'b0, 32'h1004, 1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd3, 24'h800000, 4'd0, 4'h0, 32'h02000000, 32'h0, 4'd0, 1'b1, 1'b1, 32'h01000004, 1'b1, 32'h02000005, 1'b0, 1'b0},
        '{3'd3, 24'h7FFFFF, 4'd0, 4'h0, 32'h1000, 32'h0, 4'd0, 1'b1, 1'b1, 32'h01001002, 1'b1, 32'h1005, 1'b0, 1'b0},
        '{3'd4, 24'h0, 4'd0, 4'h0, 32'h1000, 32'h20000101, 4'd3, 1'b0, 1'b1, 32'h20000100, 1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd4, 24'h0, 4'd0, 4'h0, 32'h1000, 32'h20000100, 4'd3, 1'b0, 1'b0, 32'h20000100, 1'b0, 32'h0, 1'b1, 1'b0},
        '{3'd5, 24'h0, 4'd0, 4'h0, 32'h1000, 32'h00004001, 4'd2, 1'b0, 1'b1, 32'h4000, 1'b1, 32'h1003, 1'b0, 1'b0},
        '{3'd5, 24'h0, 4'd0, 4'h0, 32'h1000, 32'h00004000, 4'd2, 1'b0, 1'b0, 32'h4000, 1'b0, 32'h0, 1'b1, 1'b0},
        '{3'd4, 24'h0, 4'd0, 4'h0, 32'h1000, 32'h00000101, 4'd13, 1'b0, 1'b1, 32'h0100, 1'b0, 32'h0, 1'b0, 1'b1},
        '{3'd5, 24'h0, 4'd0, 4'h0, 32'h1000, 32'h00000201, 4'd15, 1'b0, 1'b1, 32'h0200, 1'b1, 32'h1003, 1'b0, 1'b1},
        '{3'd1, 24'h0, 4'd0, 4'h0, 32'h1000, 32'h0, 4'd13, 1'b0, 1'b1, 32'h1004, 1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd6, 24'h12, 4'd14, 4'h0, 32'h1000, 32'h1, 4'd13, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] k);
        case (k)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R7";
            default: return "R1";
        endcase
    endfunction

    function automatic logic cond_ref(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            4'd0: return z;          4'd1: return !z;
            4'd2: return cy;         4'd3: return !cy;
            4'd4: return n;          4'd5: return !n;
            4'd6: return v;          4'd7: return !v;
            4'd8: return cy & !z;    4'd9: return !cy | z;
            4'd10: return n == v;    4'd11: return n != v;
            4'd12: return !z & (n == v);
            4'd13: return z | (n != v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic drive(input vec_t v, input logic req);
        @(negedge clk);
        req_i = req; kind_i = v.kind; off_i = v.off; cond_i = v.cond; flags_i = v.flags;
        pc_i = v.pc; rm_val_i = v.rm; rm_idx_i = v.idx; wide_i = v.wide;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reset valid", 32'(valid_o), 32'd0);
        chk("R1", "reset taken", 32'(taken_o), 32'd0);
        chk("R1", "reset target", target_o, 32'd0);
        chk("R1", "reset lr", lr_val_o, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string t;
            logic ev;
            v = VECS[i];
            t = tag_of(v.kind);
            ev = (v.kind >= 3'd1 && v.kind <= 3'd5);
            drive(v, 1'b1);
            chk(t, "valid", 32'(valid_o), 32'(ev));
            chk(t, "taken", 32'(taken_o), 32'(v.e_taken));
            chk("R9", "target", target_o, v.e_tgt);
            chk(t, "lr_we", 32'(lr_we_o), 32'(v.e_lrwe));
            chk(v.e_lrwe ? "R9" : t, "lr_val", lr_val_o, v.e_lr);
            chk("R6", "fault", 32'(fault_o), 32'(v.e_fault));
            chk("R8", "unpred", 32'(unpred_o), 32'(v.e_unpred));
        end

        // R1: request low suppresses a valid branch
        drive(VECS[0], 1'b0);
        chk("R1", "no req valid", 32'(valid_o), 32'd0);
        chk("R1", "no req taken", 32'(taken_o), 32'd0);
        chk("R1", "no req target", target_o, 32'd0);

        // R1: kind 0 with a linking-looking operand
        begin
            vec_t v0;
            v0 = VECS[12];
            v0.kind = 3'd0;
            drive(v0, 1'b1);
            chk("R1", "kind0 lr_we", 32'(lr_we_o), 32'd0);
            chk("R1", "kind0 valid", 32'(valid_o), 32'd0);
        end

        // R3: exhaustive condition sweep
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                vec_t vc;
                vc = VECS[5];
                vc.cond = 4'(c);
                vc.flags = 4'(f);
                drive(vc, 1'b1);
                chk("R3", $sformatf("cond %0d flags %h", c, f), 32'(taken_o),
                    32'(cond_ref(4'(c), 4'(f))));
            end
        end

        // R7: narrow indirect link vs wide encoding flag
        begin
            vec_t vw;
            vw = VECS[12];
            vw.wide = 1'b1;
            drive(vw, 1'b1);
            chk("R7", "wide link", lr_val_o, 32'h1005);
        end

        // R1: back-to-back requests, each result appears one edge later
        @(negedge clk);
        req_i = 1'b1; kind_i = 3'd1; off_i = 24'h0; pc_i = 32'h2000;
        @(negedge clk);
        chk("R1", "b2b first", target_o, 32'h2004);
        kind_i = 3'd4; rm_val_i = 32'h3001; rm_idx_i = 4'd1;
        @(negedge clk);
        chk("R1", "b2b second", target_o, 32'h3000);
        req_i = 1'b0;
        @(negedge clk);
        chk("R1", "b2b idle", 32'(valid_o), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule